// File: doc/BRIEF.md
# Interrupt, PWM and Cache-Mode Configuration Block

This block holds the control state that a small processor core sets up for its three hardware interrupts, its square-wave PWM pin and its serial cache. Software first places a 16-bit value in a shared staging register. A select code then copies that value into one destination: an interrupt vector, an interrupt enable bit, the PWM enable or the PWM period. When the select code is zero nothing is copied, and the staging register stays free for general use.

The PWM output is a plain toggle generator. While it is enabled, a counter runs up to the stored period. On reaching it, the counter returns to zero and the output inverts. A separate 4-bit baud-setting input switches the cache between a UART and a FIFO, and it latches a 3-bit baud code. The set and clear encodings are not symmetric: the FIFO is chosen again only by one dedicated pattern.

The reset input is asynchronous and active low. It is released synchronously, two clock edges after it rises.

Top module: `irq_pwm_cfg`

## Requirements
- R1: After reset: all vectors zero, all interrupt enables zero, PWM enable zero, PWM period zero, PWM output zero, cache mode FIFO (`uart_mode_o`=0), baud code zero.
- R2: Select codes 1, 2 and 3 copy all 16 bits of `stage_i` into vector 0, 1 and 2. Vector k occupies bits [16k+15:16k] of `vec_o`. The new value is visible after the next rising clock edge.
- R3: Select codes 4, 5 and 6 copy `stage_i[0]` into interrupt enable bit 0, 1 and 2 of `irq_en_o`. A 1 enables the interrupt and a 0 disables it.
- R4: Select code 7 copies `stage_i[0]` into the PWM enable. Select code 8 copies all 16 bits of `stage_i` into the PWM period.
- R5: Select code 0, and every code from 9 to 15, changes no vector, no enable and no period.
- R6: While the PWM is enabled, the counter increments on each edge. When the counter has reached or passed the period, it returns to zero on the next edge and the PWM output inverts. With period P the output therefore holds each level for P+1 cycles, and it first rises P+1 edges after the enable is loaded.
- R7: While the PWM is disabled, the counter and the PWM output are forced to zero on the next edge.
- R8: When `baud_i[0]` is 1, the next edge sets `uart_mode_o` to 1 and loads `baud_i[3:1]` into `baud_code_o`.
- R9: When `baud_i` is 4'b1110, the next edge clears `uart_mode_o` to 0 and leaves the baud code unchanged.
- R10: Any other `baud_i` value with bit 0 at 0 leaves both the mode and the baud code unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_i | input | 4 | Destination select for the staged value |
| stage_i | input | 16 | Contents of the interrupt staging register |
| baud_i | input | 4 | Cache mode and baud-code setting |
| vec_o | output | 48 | Three interrupt vectors, vector 0 in the low bits |
| irq_en_o | output | 3 | Interrupt enable bits |
| pwm_en_o | output | 1 | PWM enable |
| period_o | output | 16 | PWM period |
| pwm_o | output | 1 | PWM square-wave output |
| uart_mode_o | output | 1 | Cache mode: 1 for UART, 0 for FIFO |
| baud_code_o | output | 3 | Latched baud code |

## Verification
The assertions check on every cycle the rules that relate one edge to the next:
- each select code loads only its own destination, and the idle codes hold everything;
- the counter steps by one below the period, and the output inverts at the period;
- a disabled PWM is forced to zero;
- each of the three kinds of baud input has its effect.

Only the bench's scenarios can show the behaviour over many cycles. That includes the full output waveform for a chosen period (the first rise after enable, and the P+1-cycle half period, including period zero), the values after reset, and the mode and code histories across a mixed sequence of baud settings.

// File: rtl/irq_pwm_cfg_pkg.sv
package irq_pwm_cfg_pkg;
  typedef enum logic {
    CACHE_FIFO = 1'b0,
    CACHE_UART = 1'b1
  } cache_mode_e;
endpackage

// File: rtl/irq_pwm_rst_sync.sv
module irq_pwm_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/irq_pwm_cfg_regs.sv
module irq_pwm_cfg_regs #(
  parameter int DW      = 16,
  parameter int NUM_IRQ = 3,
  parameter int SEL_W   = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [SEL_W-1:0]      sel_i,
  input  logic [DW-1:0]         stage_i,
  output logic [NUM_IRQ*DW-1:0] vec_o,
  output logic [NUM_IRQ-1:0]    irq_en_o,
  output logic                  pwm_en_o,
  output logic [DW-1:0]         period_o
);
  localparam int EN_BASE     = NUM_IRQ + 1;
  localparam int PWM_EN_CODE = 2 * NUM_IRQ + 1;
  localparam int PERIOD_CODE = 2 * NUM_IRQ + 2;

  logic          pwm_en_q, pwm_en_d;
  logic [DW-1:0] period_q, period_d;

  for (genvar g = 0; g < NUM_IRQ; g++) begin : g_irq
    logic          vec_ld, en_ld;
    logic [DW-1:0] vec_q, vec_d;
    logic          en_q, en_d;

    assign vec_ld = (sel_i == SEL_W'(g + 1));
    assign en_ld  = (sel_i == SEL_W'(EN_BASE + g));

    always_comb begin
      vec_d = vec_q;
      en_d  = en_q;
      if (vec_ld) vec_d = stage_i;
      if (en_ld)  en_d  = stage_i[0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vec_q <= '0;
        en_q  <= 1'b0;
      end else begin
        vec_q <= vec_d;
        en_q  <= en_d;
      end
    end

    assign vec_o[g*DW +: DW] = vec_q;
    assign irq_en_o[g]       = en_q;

    a_r2_vec_load: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_i == SEL_W'(g + 1)) |=> (vec_o[g*DW +: DW] == $past(stage_i)));
    a_r3_en_load: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_i == SEL_W'(EN_BASE + g)) |=> (irq_en_o[g] == $past(stage_i[0])));
  end

  always_comb begin
    pwm_en_d = pwm_en_q;
    period_d = period_q;
    if (sel_i == SEL_W'(PWM_EN_CODE)) pwm_en_d = stage_i[0];
    if (sel_i == SEL_W'(PERIOD_CODE)) period_d = stage_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwm_en_q <= 1'b0;
      period_q <= '0;
    end else begin
      pwm_en_q <= pwm_en_d;
      period_q <= period_d;
    end
  end

  assign pwm_en_o = pwm_en_q;
  assign period_o = period_q;

  a_r4_period_load: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_i == SEL_W'(PERIOD_CODE)) |=> (period_o == $past(stage_i)));
  a_r5_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ((sel_i == '0) || (sel_i > SEL_W'(PERIOD_CODE))) |=>
      ($stable(vec_o) && $stable(irq_en_o) && $stable(pwm_en_o) && $stable(period_o)));
endmodule

// File: rtl/irq_pwm_gen.sv
module irq_pwm_gen #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_i,
  input  logic [DW-1:0] period_i,
  output logic          pwm_o
);
  logic [DW-1:0] cnt_q, cnt_d;
  logic          out_q, out_d;
  logic          at_end;

  assign at_end = (cnt_q >= period_i);

  always_comb begin
    cnt_d = cnt_q;
    out_d = out_q;
    if (!en_i) begin
      cnt_d = '0;
      out_d = 1'b0;
    end else if (at_end) begin
      cnt_d = '0;
      out_d = ~out_q;
    end else begin
      cnt_d = cnt_q + DW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      out_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      out_q <= out_d;
    end
  end

  assign pwm_o = out_q;

  a_r6_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && (cnt_q < period_i)) |=> ((cnt_q == $past(cnt_q) + DW'(1)) && $stable(pwm_o)));
  a_r6_toggle: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && (cnt_q >= period_i)) |=> ((cnt_q == '0) && (pwm_o != $past(pwm_o))));
  a_r7_disabled_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_i) |=> ((cnt_q == '0) && !pwm_o));
endmodule

// File: rtl/irq_pwm_cache_mode.sv
module irq_pwm_cache_mode
  import irq_pwm_cfg_pkg::*;
#(
  parameter int CODE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W:0]   baud_i,
  output logic              uart_mode_o,
  output logic [CODE_W-1:0] baud_code_o
);
  localparam logic [CODE_W:0] CLEAR_PAT = {{CODE_W{1'b1}}, 1'b0};

  cache_mode_e       mode_q, mode_d;
  logic [CODE_W-1:0] code_q, code_d;

  always_comb begin
    mode_d = mode_q;
    code_d = code_q;
    if (baud_i[0]) begin
      mode_d = CACHE_UART;
      code_d = baud_i[CODE_W:1];
    end else if (baud_i == CLEAR_PAT) begin
      mode_d = CACHE_FIFO;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= CACHE_FIFO;
      code_q <= '0;
    end else begin
      mode_q <= mode_d;
      code_q <= code_d;
    end
  end

  assign uart_mode_o = (mode_q == CACHE_UART);
  assign baud_code_o = code_q;

  a_r8_uart_set: assert property (@(posedge clk) disable iff (!rst_n)
    baud_i[0] |=> (uart_mode_o && (baud_code_o == $past(baud_i[CODE_W:1]))));
  a_r9_fifo_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (baud_i == CLEAR_PAT) |=> (!uart_mode_o && $stable(baud_code_o)));
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!baud_i[0] && (baud_i != CLEAR_PAT)) |=> ($stable(uart_mode_o) && $stable(baud_code_o)));
endmodule

// File: rtl/irq_pwm_cfg.sv
module irq_pwm_cfg #(
  parameter int DW      = 16,
  parameter int NUM_IRQ = 3,
  parameter int SEL_W   = 4,
  parameter int CODE_W  = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [SEL_W-1:0]      sel_i,
  input  logic [DW-1:0]         stage_i,
  input  logic [CODE_W:0]       baud_i,
  output logic [NUM_IRQ*DW-1:0] vec_o,
  output logic [NUM_IRQ-1:0]    irq_en_o,
  output logic                  pwm_en_o,
  output logic [DW-1:0]         period_o,
  output logic                  pwm_o,
  output logic                  uart_mode_o,
  output logic [CODE_W-1:0]     baud_code_o
);
  logic rst_int_n;

  irq_pwm_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  irq_pwm_cfg_regs #(.DW(DW), .NUM_IRQ(NUM_IRQ), .SEL_W(SEL_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .sel_i    (sel_i),
    .stage_i  (stage_i),
    .vec_o    (vec_o),
    .irq_en_o (irq_en_o),
    .pwm_en_o (pwm_en_o),
    .period_o (period_o)
  );

  irq_pwm_gen #(.DW(DW)) u_pwm (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .en_i     (pwm_en_o),
    .period_i (period_o),
    .pwm_o    (pwm_o)
  );

  irq_pwm_cache_mode #(.CODE_W(CODE_W)) u_cache (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .baud_i      (baud_i),
    .uart_mode_o (uart_mode_o),
    .baud_code_o (baud_code_o)
  );
endmodule

// File: tb/irq_pwm_cfg_bench.sv
`timescale 1ns/1ps
module irq_pwm_cfg_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  sel_i = '0;
  logic [15:0] stage_i = '0;
  logic [3:0]  baud_i = '0;
  logic [47:0] vec_o;
  logic [2:0]  irq_en_o;
  logic        pwm_en_o;
  logic [15:0] period_o;
  logic        pwm_o;
  logic        uart_mode_o;
  logic [2:0]  baud_code_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  irq_pwm_cfg u_irq_pwm_cfg (
    .clk(clk), .rst_n(rst_n), .sel_i(sel_i), .stage_i(stage_i), .baud_i(baud_i),
    .vec_o(vec_o), .irq_en_o(irq_en_o), .pwm_en_o(pwm_en_o), .period_o(period_o),
    .pwm_o(pwm_o), .uart_mode_o(uart_mode_o), .baud_code_o(baud_code_o)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // one select pulse; returns at the negedge after the loading edge
  task automatic load(input logic [3:0] s, input logic [15:0] d);
    @(negedge clk);
    sel_i = s;
    stage_i = d;
    @(negedge clk);
    sel_i = '0;
  endtask

  task automatic set_baud(input logic [3:0] b);
    @(negedge clk);
    baud_i = b;
    @(negedge clk);
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 vec", {16'h0, vec_o}, 64'h0);
    check("R1 en", {61'h0, irq_en_o}, 64'h0);
    check("R1 pwm_en", {63'h0, pwm_en_o}, 64'h0);
    check("R1 period", {48'h0, period_o}, 64'h0);
    check("R1 pwm", {63'h0, pwm_o}, 64'h0);
    check("R1 mode", {63'h0, uart_mode_o}, 64'h0);
    check("R1 code", {61'h0, baud_code_o}, 64'h0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_vectors;
    load(4'd1, 16'hA5C3);
    load(4'd2, 16'h1234);
    load(4'd3, 16'hFFFF);
    check("R2 vectors", {16'h0, vec_o}, {16'h0, 16'hFFFF, 16'h1234, 16'hA5C3});
    load(4'd2, 16'h0001);
    check("R2 vector1 reload", {16'h0, vec_o}, {16'h0, 16'hFFFF, 16'h0001, 16'hA5C3});
  endtask

  task automatic t_enables;
    load(4'd4, 16'h0001);
    check("R3 en0", {61'h0, irq_en_o}, 64'h1);
    load(4'd6, 16'hFFFF);
    check("R3 en2", {61'h0, irq_en_o}, 64'h5);
    load(4'd5, 16'h0003);
    load(4'd4, 16'hFFFE);
    check("R3 en0 off en1 on", {61'h0, irq_en_o}, 64'h6);
  endtask

  task automatic t_ignored;
    load(4'd0, 16'hBEEF);
    for (int s = 9; s < 16; s++) load(4'(s), 16'hFFFF);
    check("R5 vec unchanged", {16'h0, vec_o}, {16'h0, 16'hFFFF, 16'h0001, 16'hA5C3});
    check("R5 en unchanged", {61'h0, irq_en_o}, 64'h6);
    check("R5 pwm_en unchanged", {63'h0, pwm_en_o}, 64'h0);
    check("R5 period unchanged", {48'h0, period_o}, 64'h0);
    check("R5 pwm idle", {63'h0, pwm_o}, 64'h0);
  endtask

  task automatic t_pwm(input int p);
    load(4'd8, 16'(p));
    check("R4 period", {48'h0, period_o}, 64'(p));
    load(4'd7, 16'h0001);
    check("R4 pwm_en", {63'h0, pwm_en_o}, 64'h1);
    check("R6 pwm k0", {63'h0, pwm_o}, 64'h0);
    for (int k = 1; k <= 4 * (p + 1); k++) begin
      @(negedge clk);
      check($sformatf("R6 pwm p=%0d k=%0d", p, k), {63'h0, pwm_o}, 64'((k / (p + 1)) % 2));
    end
  endtask

  task automatic t_disable;
    load(4'd7, 16'h0000);
    @(negedge clk);
    check("R7 pwm held low", {63'h0, pwm_o}, 64'h0);
    repeat (5) @(negedge clk);
    check("R7 pwm stays low", {63'h0, pwm_o}, 64'h0);
  endtask

  task automatic t_baud;
    set_baud(4'b1011);
    check("R8 mode", {63'h0, uart_mode_o}, 64'h1);
    check("R8 code", {61'h0, baud_code_o}, 64'h5);
    set_baud(4'b0000);
    check("R10 0000 mode", {63'h0, uart_mode_o}, 64'h1);
    check("R10 0000 code", {61'h0, baud_code_o}, 64'h5);
    set_baud(4'b0110);
    check("R10 0110 mode", {63'h0, uart_mode_o}, 64'h1);
    set_baud(4'b1110);
    check("R9 mode", {63'h0, uart_mode_o}, 64'h0);
    check("R9 code kept", {61'h0, baud_code_o}, 64'h5);
    set_baud(4'b1000);
    check("R10 1000 mode", {63'h0, uart_mode_o}, 64'h0);
    set_baud(4'b0001);
    check("R8 code zero", {61'h0, baud_code_o}, 64'h0);
    check("R8 mode again", {63'h0, uart_mode_o}, 64'h1);
    set_baud(4'b1111);
    check("R8 code max", {61'h0, baud_code_o}, 64'h7);
    set_baud(4'b0100);
    check("R10 0100 code", {61'h0, baud_code_o}, 64'h7);
  endtask

  initial begin
    t_reset();
    t_vectors();
    t_enables();
    t_ignored();
    t_pwm(3);
    t_disable();
    t_pwm(0);
    t_disable();
    t_pwm(6);
    t_disable();
    t_baud();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule